// File: doc/BRIEF.md
# Seconds-Based Watchdog Timer

This block is a countdown watchdog that a configuration front end programs through an index/data register strobe. An 8-bit timeout register holds the remaining time. A nonzero write arms or re-arms the counter from that value, and a zero write stops it. Reading the same index returns the live remaining count. An internal prescaler turns the system clock into a one-cycle tick once per second. A control bit can stretch that tick to once per minute.

When the count steps from 1 to 0, a sticky expiry flag is set. If the control register allows it, an active-low reset output also pulses low for a fixed number of clock cycles. Keyboard or mouse activity inputs can reload the counter from the last programmed value. Each source has its own enables. An optional nonzero reset value lets the watchdog run straight out of reset.

Top module: `sec_watchdog`

## Requirements
- R1: A data write of value N (1..255) to index 0xF6 loads the count with N and clears the prescaler phase. The count then drops by one every time unit, with the first drop exactly one full unit after the write. A second is CLK_HZ clock cycles.
- R2: A data write of 0 to index 0xF6 stops the watchdog. The count stays 0, no expiry is flagged and the reset output stays high.
- R3: With the index register at 0xF6, the read data shows the live remaining count in every cycle.
- R4: On the tick where the count goes from 1 to 0, status bit 4 (index 0xF7) becomes 1 and stays 1. A data write to 0xF7 with bit 4 clear resets it.
- R5: When control bit 1 (index 0xF5) is set, an expiry drives the reset output low for exactly PULSE_CYCLES cycles, starting in the expiry cycle. When the bit is clear, the output stays high.
- R6: Control bit 3 clear selects seconds. Control bit 3 set selects minutes, so one count lasts 60·CLK_HZ cycles.
- R7: A keyboard event reloads the count from the last programmed value and clears the prescaler phase. This happens only when control bit 2 is set, status bit 6 is set and the count is nonzero. Otherwise the event has no effect.
- R8: A mouse event reloads the count in the same way. This happens only when status bit 7 is set and the count is nonzero.
- R9: After reset, the count equals INIT_TIMEOUT, the control register is 0, the expiry flag is clear and the index selects 0xF6. A nonzero INIT_TIMEOUT counts down at once.
- R10: The control register reads back as written. An index other than 0xF5, 0xF6 or 0xF7 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock at CLK_HZ |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_idx_we_i | input | 1 | Strobe: load the index register from cfg_wdata_i |
| cfg_dat_we_i | input | 1 | Strobe: write cfg_wdata_i to the indexed register |
| cfg_wdata_i | input | 8 | Index or data byte |
| cfg_rdata_o | output | 8 | Contents of the indexed register |
| kbd_evt_i | input | 1 | One-cycle keyboard activity event |
| mouse_evt_i | input | 1 | One-cycle mouse activity event |
| wdt_rst_no | output | 1 | Active-low reset pulse on expiry |

## Verification
The countdown is swept over timeout values 1 to 40, plus 255. Pulse enable alternates between runs, and the count and reset pin are compared every cycle. This separates off-by-one errors in the tick period, the expiry cycle and the pulse length. A minute-mode run shows whether the unit selector stretches the tick.

Re-writes and activity events are placed in the middle of a second. This checks that the prescaler phase is cleared. Each event is also tried with one enable missing at a time, and with the counter stopped, to confirm each gate on its own. The stop write, the unknown index and the nonzero reset value each show whether the watchdog arms, runs or stays quiet as required.

// File: rtl/sec_wdt_pkg.sv
package sec_wdt_pkg;

    localparam logic [7:0] IDX_CTRL = 8'hF5;
    localparam logic [7:0] IDX_TMO  = 8'hF6;
    localparam logic [7:0] IDX_STAT = 8'hF7;

    localparam int CTRL_PULSE_BIT  = 1;
    localparam int CTRL_KBD_BIT    = 2;
    localparam int CTRL_MINUTE_BIT = 3;

    localparam int STAT_MOUSE_BIT = 7;
    localparam int STAT_KBD_BIT   = 6;
    localparam int STAT_EXP_BIT   = 4;

    localparam int SECS_PER_MIN = 60;

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] count;
        logic [7:0] reload;
        logic [7:0] ctrl;
        logic       kbd_en;
        logic       mouse_en;
        logic       expired;
    } wdt_regs_t;

endpackage

// File: rtl/sw_tick_div.sv
module sw_tick_div #(
    parameter int CLK_HZ = 32768
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic minute_i,
    output logic unit_tick_o
);
    import sec_wdt_pkg::*;

    localparam int SW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam int MW = $clog2(SECS_PER_MIN);

    typedef struct packed {
        logic [SW-1:0] sec;
        logic [MW-1:0] min;
    } div_t;

    div_t q, d;
    logic sec_tick;

    always_comb begin
        d        = q;
        sec_tick = (q.sec == SW'(CLK_HZ - 1));
        unit_tick_o = sec_tick && (!minute_i || q.min == MW'(SECS_PER_MIN - 1));
        if (clr_i) begin
            d.sec = '0;
            d.min = '0;
        end else if (sec_tick) begin
            d.sec = '0;
            if (!minute_i || q.min == MW'(SECS_PER_MIN - 1)) d.min = '0;
            else                                              d.min = q.min + 1'b1;
        end else begin
            d.sec = q.sec + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

endmodule

// File: rtl/sw_rst_pulse.sv
module sw_rst_pulse #(
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    output logic rst_no
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);

    logic [PW-1:0] left_q, left_d;

    always_comb begin
        left_d = left_q;
        if (fire_i)            left_d = PW'(PULSE_CYCLES);
        else if (left_q != '0) left_d = left_q - 1'b1;
    end

    assign rst_no = (left_q == '0);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) left_q <= '0;
        else         left_q <= left_d;
    end

endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog #(
    parameter int         CLK_HZ       = 32768,
    parameter int         PULSE_CYCLES = 16,
    parameter logic [7:0] INIT_TIMEOUT = 8'd0
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cfg_idx_we_i,
    input  logic       cfg_dat_we_i,
    input  logic [7:0] cfg_wdata_i,
    output logic [7:0] cfg_rdata_o,
    input  logic       kbd_evt_i,
    input  logic       mouse_evt_i,
    output logic       wdt_rst_no
);
    import sec_wdt_pkg::*;

    wdt_regs_t q, d;
    logic wr_tmo, kbd_hit, mouse_hit, restart, unit_tick, expire, fire;

    always_comb begin
        wr_tmo    = cfg_dat_we_i && (q.idx == IDX_TMO);
        kbd_hit   = kbd_evt_i && q.ctrl[CTRL_KBD_BIT] && q.kbd_en && (q.count != 8'd0);
        mouse_hit = mouse_evt_i && q.mouse_en && (q.count != 8'd0);
        restart   = !wr_tmo && (kbd_hit || mouse_hit);
        expire    = !wr_tmo && !restart && unit_tick && (q.count == 8'd1);
        fire      = expire && q.ctrl[CTRL_PULSE_BIT];
    end

    sw_tick_div #(.CLK_HZ(CLK_HZ)) i_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (wr_tmo || restart),
        .minute_i   (q.ctrl[CTRL_MINUTE_BIT]),
        .unit_tick_o(unit_tick)
    );

    sw_rst_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) i_pulse (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .fire_i(fire),
        .rst_no(wdt_rst_no)
    );

    always_comb begin
        d = q;
        if (cfg_idx_we_i) d.idx = cfg_wdata_i;
        if (cfg_dat_we_i) begin
            unique case (q.idx)
                IDX_TMO: begin
                    d.count  = cfg_wdata_i;
                    d.reload = cfg_wdata_i;
                end
                IDX_CTRL: d.ctrl = cfg_wdata_i;
                IDX_STAT: begin
                    d.mouse_en = cfg_wdata_i[STAT_MOUSE_BIT];
                    d.kbd_en   = cfg_wdata_i[STAT_KBD_BIT];
                    if (!cfg_wdata_i[STAT_EXP_BIT]) d.expired = 1'b0;
                end
                default: ;
            endcase
        end
        if (restart)                                   d.count = q.reload;
        else if (!wr_tmo && unit_tick && q.count != 0) d.count = q.count - 8'd1;
        if (expire) d.expired = 1'b1;
    end

    always_comb begin
        unique case (q.idx)
            IDX_TMO:  cfg_rdata_o = q.count;
            IDX_CTRL: cfg_rdata_o = q.ctrl;
            IDX_STAT: cfg_rdata_o = {q.mouse_en, q.kbd_en, 1'b0, q.expired, 4'b0000};
            default:  cfg_rdata_o = 8'd0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q          <= '0;
            q.idx      <= IDX_TMO;
            q.count    <= INIT_TIMEOUT;
            q.reload   <= INIT_TIMEOUT;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/sec_watchdog_chk.sv
module sec_watchdog_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       dat_we,
    input logic [7:0] wdata,
    input logic [7:0] idx,
    input logic [7:0] count,
    input logic       expired,
    input logic       pulse_en,
    input logic       kbd_evt,
    input logic       mouse_evt,
    input logic       rst_out_n
);
    import sec_wdt_pkg::*;

    p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dat_we && idx == IDX_TMO) |=> (count == $past(wdata)));

    p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dat_we && !kbd_evt && !mouse_evt) |=>
        (count == $past(count) || count == $past(count) - 8'd1));

    p_stop_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count == 8'd0 && !(dat_we && idx == IDX_TMO)) |=> (count == 8'd0));

    p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expired && !(dat_we && idx == IDX_STAT)) |=> expired);

    p_expire_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count == 8'd1 && !dat_we && !kbd_evt && !mouse_evt) |=>
        (count == 8'd1 || expired));

    p_pulse_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_out_n) |-> ($past(count) == 8'd1 && count == 8'd0 && $past(pulse_en)));

endmodule

bind sec_watchdog sec_watchdog_chk i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dat_we   (cfg_dat_we_i),
    .wdata    (cfg_wdata_i),
    .idx      (q.idx),
    .count    (q.count),
    .expired  (q.expired),
    .pulse_en (q.ctrl[1]),
    .kbd_evt  (kbd_evt_i),
    .mouse_evt(mouse_evt_i),
    .rst_out_n(wdt_rst_no)
);

// File: tb/test_sec_watchdog.sv
module test_sec_watchdog;

    localparam int CLK_PERIOD = 10;
    localparam int C  = 4;
    localparam int P  = 3;
    localparam logic [7:0] INIT = 8'd3;
    localparam logic [7:0] I_CTRL = 8'hF5;
    localparam logic [7:0] I_TMO  = 8'hF6;
    localparam logic [7:0] I_STAT = 8'hF7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_we = 1'b0, dat_we = 1'b0, kbd = 1'b0, mouse = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       wrst_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_watchdog #(.CLK_HZ(C), .PULSE_CYCLES(P), .INIT_TIMEOUT(INIT)) i_sec_watchdog (
        .clk_i(clk), .rst_ni(rst_n), .cfg_idx_we_i(idx_we), .cfg_dat_we_i(dat_we),
        .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .kbd_evt_i(kbd),
        .mouse_evt_i(mouse), .wdt_rst_no(wrst_n));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_idx(input logic [7:0] i);
        idx_we = 1'b1; wdata = i;
        step(1);
        idx_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] i, input logic [7:0] v);
        set_idx(i);
        dat_we = 1'b1; wdata = v;
        step(1);
        dat_we = 1'b0;
    endtask

    // countdown run: expiry edge at n*C*U after the timeout write
    task automatic run_seq(input int n, input bit pen, input bit minute, input string tag);
        int u = minute ? 60 : 1;
        int span = n * C * u;
        wr(I_CTRL, {4'b0, minute, 1'b0, pen, 1'b0});
        wr(I_STAT, 8'h00);
        wr(I_TMO, 8'(n));
        for (int m = 1; m <= span + P + 1; m++) begin
            step(1);
            check(tag, rdata, (m >= span) ? 0 : n - m / (C * u));
            check("R5 pulse", wrst_n, (pen && m >= span && m < span + P) ? 0 : 1);
        end
        set_idx(I_STAT);
        check("R4 sticky expiry", rdata[4], 1);
        wr(I_STAT, 8'h00);
        check("R4 clear expiry", rdata[4], 0);
    endtask

    // event at edge 7 after writing 5; reload gives 5, else schedule gives 4
    task automatic evt_test(input logic [7:0] ctrl, input logic [7:0] stat,
                            input bit use_kbd, input bit reload, input string tag);
        wr(I_CTRL, ctrl);
        wr(I_STAT, stat);
        wr(I_TMO, 8'd5);
        step(6);
        check(tag, rdata, 4);
        if (use_kbd) kbd = 1'b1; else mouse = 1'b1;
        step(1);
        kbd = 1'b0; mouse = 1'b0;
        if (reload) begin
            check(tag, rdata, 5);
            step(3);
            check(tag, rdata, 5);
            step(1);
            check(tag, rdata, 4);
        end else begin
            check(tag, rdata, 4);
            step(1);
            check(tag, rdata, 3);
        end
        wr(I_TMO, 8'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R9: reset state with nonzero initial timeout runs at once
        check("R9 reset count", rdata, INIT);
        check("R9 reset pin", wrst_n, 1);
        for (int m = 1; m <= 14; m++) begin
            step(1);
            check("R9 init countdown", rdata, (m >= 12) ? 0 : 3 - m / C);
            check("R5 no pulse when disabled", wrst_n, 1);
        end
        set_idx(I_CTRL);
        check("R9 ctrl reset", rdata, 0);
        set_idx(I_STAT);
        check("R9 expiry after init run", rdata, 8'h10);
        wr(I_STAT, 8'h00);

        // R1/R3/R5 sweep
        for (int n = 1; n <= 40; n++) run_seq(n, n[0], 1'b0, "R1 R3 countdown");
        run_seq(255, 1'b1, 1'b0, "R1 max timeout");
        // R6 minute unit
        run_seq(2, 1'b1, 1'b1, "R6 minute mode");

        // R1 phase clear on re-write
        wr(I_CTRL, 8'h00);
        wr(I_TMO, 8'd3);
        step(6);
        check("R1 before rewrite", rdata, 2);
        wr(I_TMO, 8'd3);
        check("R1 rewrite load", rdata, 3);
        step(3);
        check("R1 full second after write", rdata, 3);
        step(1);
        check("R1 first decrement", rdata, 2);

        // R2 stop
        wr(I_CTRL, 8'h02);
        wr(I_TMO, 8'd2);
        step(5);
        check("R2 running", rdata, 1);
        wr(I_TMO, 8'd0);
        for (int m = 0; m < 20; m++) begin
            step(1);
            check("R2 stopped count", rdata, 0);
            check("R2 no pulse", wrst_n, 1);
        end
        set_idx(I_STAT);
        check("R2 no expiry", rdata[4], 0);

        // R7 keyboard gating, R8 mouse gating
        evt_test(8'h04, 8'h40, 1'b1, 1'b1, "R7 kbd reload");
        evt_test(8'h00, 8'h40, 1'b1, 1'b0, "R7 kbd ctrl gate");
        evt_test(8'h04, 8'h00, 1'b1, 1'b0, "R7 kbd status gate");
        evt_test(8'h00, 8'h80, 1'b0, 1'b1, "R8 mouse reload");
        evt_test(8'h04, 8'h40, 1'b0, 1'b0, "R8 mouse gate");
        wr(I_STAT, 8'hC0);
        wr(I_CTRL, 8'h04);
        set_idx(I_TMO);
        kbd = 1'b1; mouse = 1'b1;
        step(1);
        kbd = 1'b0; mouse = 1'b0;
        step(2);
        check("R7 R8 no reload when stopped", rdata, 0);

        // R10 register decode
        wr(I_CTRL, 8'h5A);
        check("R10 ctrl readback", rdata, 8'h5A);
        wr(I_CTRL, 8'h00);
        wr(8'h10, 8'hAA);
        check("R10 unknown index reads 0", rdata, 0);
        set_idx(I_TMO);
        check("R10 unknown write no effect", rdata, 0);
        set_idx(I_CTRL);
        check("R10 ctrl untouched", rdata, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule